// File: doc/BRIEF.md
# PDM-to-PCM CIC Decimator with Output Gain

This block turns a one-bit pulse-density stream into signed multi-bit samples. Each input bit that arrives with its valid strobe counts as +1 when it is one and -1 when it is zero. The values run through a cascade of integrators, are thinned out by a programmable decimation ratio, and then pass through an equal number of comb stages. The comb result is multiplied by an unsigned 8-bit gain factor, shifted right arithmetically by a programmable amount, and saturated to a 24-bit signed sample. The sample leaves with a one-cycle valid strobe at the decimated rate.

The block is configured by one 32-bit control word. It holds the number of stages, the decimation ratio, the gain factor, the shift amount and an enable bit. While the enable bit is clear, the filter state and the decimation phase are held cleared and no samples are produced. The control word is meant to be changed only while the block is disabled.

Top module: `pdm_cic_decim`

## Requirements
- R1: After reset, `pcm_valid` is 0 and `pcm_data` is 0.
- R2: An input bit of 1 counts as +1 and a bit of 0 counts as -1. With a constant input, the settled output equals ±(ratio^stages) times the gain factor, shifted right arithmetically. With the power-on style settings (stages 7, ratio 8, gain 0x80, shift 0x15), an all-ones stream settles to +128 and an all-zeros stream settles to -128.
- R3: The stage count is taken from control bits 3:0. A value of 0 acts as 1 stage, and a value above the configured maximum (default 8) acts as the maximum.
- R4: The decimation ratio is taken from control bits 8:4. A value of 0 acts as 1. Any ratio from 1 to 31 is allowed, odd ratios included.
- R5: After the block is enabled, `pcm_valid` pulses exactly once for every ratio accepted input bits. Only bits presented with `pdm_valid` high are accepted, and bits on cycles with `pdm_valid` low have no effect on the result.
- R6: The gain factor is control bits 23:16, treated as unsigned. The shift amount is control bits 29:24. The product is shifted right arithmetically, rounding toward minus infinity, so -3 shifted by 1 gives -2. A gain factor of 0 gives an output of 0.
- R7: A shifted result above 8388607 is output as 8388607, and one below -8388608 is output as -8388608.
- R8: Control bit 31 enables the block. While it is clear, input bits are ignored and `pcm_valid` stays 0 from the cycle after the bit is seen low.
- R9: `pcm_data` changes only in a cycle where `pcm_valid` is high. A `pcm_valid` pulse follows three clock edges after the accepted input bit that completes a decimation period.
- R10: Periodic streams whose period divides the ratio settle to their mean times the DC gain. Alternating bits with an even ratio settle to 0, and the repeating pattern 1,1,1,0 with a ratio of 8 settles to half of the all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 32 | Control word: enable (31), shift (29:24), gain (23:16), ratio (8:4), stages (3:0) |
| pdm_bit | input | 1 | One-bit pulse-density input |
| pdm_valid | input | 1 | Strobe marking `pdm_bit` as a new input sample |
| pcm_data | output | 24 | Signed decimated and scaled output sample |
| pcm_valid | output | 1 | One-cycle strobe for a new `pcm_data` |

## Verification
Constant all-ones and all-zeros streams show that the DC gain is ratio^stages with the correct sign, and that the multiply, shift and saturation are correct. These are run across several stage and ratio settings, including the clamped field values and an odd ratio. Alternating bits and the 1,1,1,0 pattern show whether the comb zeros cancel out-of-band content or whether only the mean passes. A stream with idle cycles carrying zeros shows whether un-strobed bits leak in. Output counting over an exact number of periods, and a run with the enable bit clear, separate a correct decimation phase from a missing or extra strobe.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;

  localparam int RATIO_W = 5;
  localparam int STG_W   = 4;
  localparam int GAIN_W  = 8;
  localparam int SHIFT_W = 6;

  typedef struct packed {
    logic               en;
    logic [SHIFT_W-1:0] shift;
    logic [GAIN_W-1:0]  gain;
    logic [RATIO_W-1:0] ratio;
    logic [STG_W-1:0]   stages;
  } cic_cfg_t;

  function automatic cic_cfg_t decode_ctrl(input logic [31:0] w);
    cic_cfg_t c;
    c.en     = w[31];
    c.shift  = w[29:24];
    c.gain   = w[23:16];
    c.ratio  = w[8:4];
    c.stages = w[3:0];
    return c;
  endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int W  = 41,
  parameter int NS = 8,
  parameter int SW = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         bit_in,
  input  logic [SW-1:0] sel,
  output logic [W-1:0] dout
);

  logic [W-1:0] acc [NS];
  logic [W-1:0] x_in;

  assign x_in = bit_in ? W'(1) : {W{1'b1}};

  for (genvar k = 0; k < NS; k++) begin : g_stage
    logic [W-1:0] addend;
    if (k == 0) begin : g_first
      assign addend = x_in;
    end else begin : g_next
      assign addend = acc[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr) acc[k] <= '0;
      else if (step)  acc[k] <= acc[k] + addend;
    end
  end

  assign dout = acc[sel];

endmodule

// File: rtl/cic_phase_ctr.sv
module cic_phase_ctr #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [RW-1:0] ratio,
  output logic          dump
);

  logic [RW-1:0] cnt;
  logic          last;

  assign last = (cnt >= ratio - RW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      dump <= 1'b0;
    end else if (step) begin
      dump <= last;
      cnt  <= last ? '0 : cnt + RW'(1);
    end else begin
      dump <= 1'b0;
    end
  end

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int W  = 41,
  parameter int NS = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  dout,
  output logic          dvalid
);

  logic [W-1:0] y   [NS];
  logic [W-1:0] dly [NS];

  for (genvar k = 0; k < NS; k++) begin : g_stage
    logic [W-1:0] src;
    if (k == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = y[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        y[k]   <= '0;
        dly[k] <= '0;
      end else if (step) begin
        y[k]   <= src - dly[k];
        dly[k] <= src;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) dvalid <= 1'b0;
    else            dvalid <= step;
  end

  assign dout = y[sel];

endmodule

// File: rtl/cic_gain_sat.sv
module cic_gain_sat #(
  parameter int W   = 41,
  parameter int GW  = 8,
  parameter int SHW = 6,
  parameter int OW  = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic [W-1:0]   din,
  input  logic [GW-1:0]  gain,
  input  logic [SHW-1:0] shift,
  output logic [OW-1:0]  q,
  output logic           qv
);

  localparam int PW = W + GW + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;
  logic [PW-OW:0]       top;
  logic                 fits;
  logic [OW-1:0]        sat;

  always_comb begin
    prod    = PW'($signed(din)) * PW'($signed({1'b0, gain}));
    shifted = prod >>> shift;
    top     = shifted[PW-1:OW-1];
    fits    = (&top) || (~|top);
    if (fits)              sat = shifted[OW-1:0];
    else if (shifted[PW-1]) sat = {1'b1, {(OW-1){1'b0}}};
    else                   sat = {1'b0, {(OW-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      qv <= 1'b0;
    end else if (clr) begin
      qv <= 1'b0;
    end else begin
      qv <= step;
      if (step) q <= sat;
    end
  end

endmodule

// File: rtl/pdm_cic_decim.sv
module pdm_cic_decim
  import pdm_cic_pkg::*;
#(
  parameter int MAX_STAGES = 8,
  parameter int OUT_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      ctrl,
  input  logic             pdm_bit,
  input  logic             pdm_valid,
  output logic [OUT_W-1:0] pcm_data,
  output logic             pcm_valid
);

  localparam int ACC_W = 1 + MAX_STAGES * RATIO_W;
  localparam int SEL_W = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1;

  cic_cfg_t      cfg;
  logic [SEL_W-1:0] sel;
  logic [RATIO_W-1:0] ratio_eff;
  logic          clr;
  logic          step;
  logic          dump;
  logic [ACC_W-1:0] integ_q;
  logic [ACC_W-1:0] comb_q;
  logic          comb_v;

  always_comb begin
    cfg = decode_ctrl(ctrl);
    clr = ~cfg.en;
    step = pdm_valid & cfg.en;
    ratio_eff = (cfg.ratio == '0) ? RATIO_W'(1) : cfg.ratio;
    if (cfg.stages == '0)                              sel = '0;
    else if (32'(cfg.stages) > MAX_STAGES)             sel = SEL_W'(MAX_STAGES - 1);
    else                                               sel = SEL_W'(cfg.stages - STG_W'(1));
  end

  cic_integ_chain #(.W(ACC_W), .NS(MAX_STAGES), .SW(SEL_W)) u_integ (
    .clk(clk), .rst(rst), .clr(clr), .step(step),
    .bit_in(pdm_bit), .sel(sel), .dout(integ_q)
  );

  cic_phase_ctr #(.RW(RATIO_W)) u_phase (
    .clk(clk), .rst(rst), .clr(clr), .step(step),
    .ratio(ratio_eff), .dump(dump)
  );

  cic_comb_chain #(.W(ACC_W), .NS(MAX_STAGES), .SW(SEL_W)) u_comb (
    .clk(clk), .rst(rst), .clr(clr), .step(dump),
    .din(integ_q), .sel(sel), .dout(comb_q), .dvalid(comb_v)
  );

  cic_gain_sat #(.W(ACC_W), .GW(GAIN_W), .SHW(SHIFT_W), .OW(OUT_W)) u_gain (
    .clk(clk), .rst(rst), .clr(clr), .step(comb_v),
    .din(comb_q), .gain(cfg.gain), .shift(cfg.shift),
    .q(pcm_data), .qv(pcm_valid)
  );

endmodule

// File: rtl/pdm_cic_decim_chk.sv
module pdm_cic_decim_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      ctrl,
  input logic             pdm_bit,
  input logic             pdm_valid,
  input logic [OUT_W-1:0] pcm_data,
  input logic             pcm_valid
);

  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(!ctrl[31])) |-> !pcm_valid);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !pcm_valid) |-> $stable(pcm_data));

  // R9
  strobe_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (warm && pcm_valid) |-> $past(pdm_valid, 3));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (pcm_valid && ctrl[8:4] >= 5'd2) |=> !pcm_valid);

  // R6
  zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (pcm_valid && ctrl[23:16] == 8'd0 && $stable(ctrl)) |-> pcm_data == '0);

endmodule

bind pdm_cic_decim pdm_cic_decim_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .pdm_bit(pdm_bit),
  .pdm_valid(pdm_valid), .pcm_data(pcm_data), .pcm_valid(pcm_valid)
);

// File: tb/pdm_cic_decim_test.sv
module pdm_cic_decim_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl = 32'd0;
  logic        pdm_bit = 1'b0;
  logic        pdm_valid = 1'b0;
  logic [23:0] pcm_data;
  logic        pcm_valid;

  int tests_run = 0;
  int tests_bad = 0;

  bit mon_on = 1'b0;
  int mon_seen = 0;
  int mon_skip = 0;
  int mon_chk = 0;
  int mon_bad = 0;
  int mon_exp = 0;
  int mon_last = 0;

  always #4 clk = ~clk;

  pdm_cic_decim uut (
    .clk(clk), .rst(rst), .ctrl(ctrl), .pdm_bit(pdm_bit),
    .pdm_valid(pdm_valid), .pcm_data(pcm_data), .pcm_valid(pcm_valid)
  );

  always @(negedge clk) begin
    if (mon_on && pcm_valid) begin
      mon_seen = mon_seen + 1;
      if (mon_seen > mon_skip) begin
        mon_chk = mon_chk + 1;
        if (32'($signed(pcm_data)) != mon_exp) begin
          mon_bad = mon_bad + 1;
          mon_last = 32'($signed(pcm_data));
        end
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests_run = tests_run + 1;
    tests_bad = tests_bad + 1;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  function automatic logic [31:0] mk(input int st, input int ra, input int gn, input int sh);
    return {1'b0, 1'b0, 6'(sh), 8'(gn), 7'd0, 5'(ra), 4'(st)};
  endfunction

  function automatic logic pat_bit(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return (i % 2) == 0;
      default: return (i % 4) != 3;
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    tests_run = tests_run + 1;
    if (!ok) begin
      tests_bad = tests_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [31:0] cfg);
    @(negedge clk);
    pdm_valid = 1'b0;
    ctrl = cfg;
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    mon_seen = 0; mon_chk = 0; mon_bad = 0;
    ctrl = cfg | 32'h8000_0000;
    mon_on = 1'b1;
  endtask

  // Settled-value scenario; gaps inserts idle cycles carrying a 0 bit.
  task automatic run_settle(input string tag, input logic [31:0] cfg, input int p,
                            input bit gaps, input int exp);
    int i;
    mon_skip = 20;
    mon_exp = exp;
    mon_last = exp;
    restart(cfg);
    i = 0;
    while (mon_seen < 28) begin
      pdm_bit = pat_bit(p, i);
      pdm_valid = 1'b1;
      i = i + 1;
      @(negedge clk);
      if (gaps) begin
        pdm_bit = 1'b0;
        pdm_valid = 1'b0;
        @(negedge clk);
      end
    end
    pdm_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(tag, mon_bad == 0 && mon_chk >= 8, mon_last, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", pcm_valid == 1'b0, int'(pcm_valid), 0);
    check("R1 data", pcm_data == 24'd0, int'(pcm_data), 0);
  endtask

  task automatic t_count();
    mon_skip = 1000;
    restart(mk(7, 8, 128, 21));
    for (int i = 0; i < 80; i++) begin
      pdm_bit = 1'b1;
      pdm_valid = (i >= 0);
      @(negedge clk);
    end
    pdm_valid = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 strobe count", mon_seen == 10, mon_seen, 10);
  endtask

  task automatic t_disabled();
    mon_skip = 1000;
    @(negedge clk);
    ctrl = mk(7, 8, 128, 21);
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    mon_seen = 0;
    for (int i = 0; i < 100; i++) begin
      pdm_bit = i[0];
      pdm_valid = 1'b1;
      @(negedge clk);
    end
    pdm_valid = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 disabled outputs", mon_seen == 0, mon_seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_settle("R2 ones default", mk(7, 8, 128, 21), 0, 1'b0, 128);
    run_settle("R2 zeros default", mk(7, 8, 128, 21), 1, 1'b0, -128);
    run_settle("R10 alternating", mk(7, 8, 128, 21), 2, 1'b0, 0);
    run_settle("R10 three-of-four", mk(7, 8, 128, 21), 3, 1'b0, 64);
    run_settle("R5 idle bits ignored", mk(7, 8, 128, 21), 0, 1'b1, 128);
    run_settle("R3 two stages", mk(2, 4, 1, 0), 0, 1'b0, 16);
    run_settle("R3 zero stages", mk(0, 5, 1, 0), 0, 1'b0, 5);
    run_settle("R3 stage clamp", mk(15, 2, 1, 0), 0, 1'b0, 256);
    run_settle("R4 odd ratio", mk(1, 31, 1, 0), 0, 1'b0, 31);
    run_settle("R4 zero ratio", mk(3, 0, 1, 0), 0, 1'b0, 1);
    run_settle("R6 floor shift", mk(1, 3, 1, 1), 1, 1'b0, -2);
    run_settle("R6 zero gain", mk(7, 8, 0, 0), 0, 1'b0, 0);
    run_settle("R7 positive clip", mk(6, 16, 255, 0), 0, 1'b0, 8388607);
    run_settle("R7 negative clip", mk(6, 16, 255, 0), 1, 1'b0, -8388608);
    t_count();
    t_disabled();
    summary();
    $finish;
  end

endmodule